// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the bus side of an eight-input vectored interrupt controller. A host reaches it through a chip select, read and write strobes, a one-bit address and an 8-bit data bus. Writes to the two addresses go through an initialization sequencer. One command word always restarts that sequence. Later words are taken in turn as the vector base, the cascade map and the mode word, and a step is skipped when an earlier field says it is not needed. Once the sequence completes, writes become mask loads, end-of-interrupt and priority commands, or read-select commands.

The block drives the configuration fields and one-cycle command pulses into a separate resolver core. It steers reads among the resolver's request and in-service vectors, its own mask register, and the poll word. The resolver's interrupt request passes to the output only after initialization is complete. All strobes are sampled synchronously on the rising clock edge. Registered outputs change in the cycle after the write.

Top module: `pic_cmd_if`

## Requirements
- R1: After reset the block is uninitialized: `init_done`, `int_out`, `mask_out`, all configuration outputs, `rot_aeoi`, `spec_mask` and `cmd_vld` are 0.
- R2: A write with `a0`=0 and `wdata[4]`=1 starts initialization from any state. It captures `wdata[0]` (mode word needed), `wdata[1]` (1 = single, 0 = cascade) and `wdata[3]` (1 = level trigger). It clears the mask, the vector base, the slave map, the mode fields, the special-mask flag, the rotate-in-auto-EOI flag and any pending poll, and it selects the request vector for reads. `init_done` falls.
- R3: The next write loads the vector base from `wdata[7:3]`; `vec_base[2:0]` reads 0.
- R4: The slave-map word follows the vector word only in cascade mode, and it is stored whole in `slave_map`.
- R5: The mode word follows only when the first word had bit 0 set. Its bits map as 0 processor mode, 1 auto-EOI, 2 master select, 3 buffered, 4 special nested. Without it those fields stay 0 and `init_done` rises after the last expected word.
- R6: During the sequence, any write that is not a restart is taken as the next expected word, whatever `a0` is.
- R7: `int_out` follows `int_req` only while `init_done` is 1.
- R8: After initialization, a write with `a0`=1 loads `mask_out`. Such writes before initialization leave it unchanged.
- R9: After initialization, a write with `a0`=0 and `wdata[4:3]`=00 is a priority command. The op `wdata[7:5]` and level `wdata[2:0]` appear on `cmd_op`/`cmd_lvl` with a one-cycle `cmd_vld` pulse for ops 001, 011, 101, 110 and 111. Op 100 sets `rot_aeoi` and op 000 clears it, with no pulse. Op 010 does nothing.
- R10: After initialization, a write with `a0`=0 and `wdata[4:3]`=01 is a read-select command. Bits 1:0 = 10 select the request vector, 11 select the in-service vector, and 0x keep the current selection. When bit 6 is 1, `spec_mask` takes bit 5.
- R11: While `cs` and `rd_stb` are high, `rdata` is the mask when `a0`=1 and the selected vector when `a0`=0. Otherwise `rdata` is 0.
- R12: Bit 2 of a read-select command arms a poll. The next read returns `{poll_hit, 0000, poll_lvl}` regardless of `a0` and raises `poll_ack` during that read, and the poll is then disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| rd_stb | input | 1 | Read strobe |
| a0 | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| irr_in | input | 8 | Request vector from resolver |
| isr_in | input | 8 | In-service vector from resolver |
| poll_hit | input | 1 | Resolver has a pending request to report |
| poll_lvl | input | 3 | Highest-priority pending level |
| int_req | input | 1 | Interrupt request from resolver |
| int_out | output | 1 | Gated interrupt request to the processor |
| poll_ack | output | 1 | Poll word is being read |
| init_done | output | 1 | Initialization sequence complete |
| vec_base | output | 8 | Vector base, low three bits 0 |
| level_trig | output | 1 | 1 = level-triggered inputs |
| cascade_en | output | 1 | Cascade mode |
| slave_map | output | 8 | Slave bitmap or identity |
| proc_mode | output | 1 | Processor mode bit |
| auto_eoi | output | 1 | Automatic end of interrupt |
| master_sel | output | 1 | Master/slave select |
| buffered | output | 1 | Buffered mode |
| nest_special | output | 1 | Special nested mode |
| mask_out | output | 8 | Interrupt mask |
| spec_mask | output | 1 | Special mask mode |
| rot_aeoi | output | 1 | Rotate in automatic EOI mode |
| cmd_vld | output | 1 | Priority command pulse |
| cmd_op | output | 3 | Priority command op |
| cmd_lvl | output | 3 | Priority command level |

## Verification
The embedded assertions watch the sequencer and the command decoder on every cycle. They check that a restart always lands on the vector step, that the vector base tracks the written word, that a single-mode sequence without a mode word ends right after the vector word, that the mask is frozen before initialization, that command pulses come only from valid command writes, and that a poll acknowledge never repeats. The skip paths of the sequence, mid-sequence writes on either address, read steering under each select code, special-mask updates, the poll word contents and the clearing effect of a restart depend on whole write sequences. Only the bench's scenarios show those, checked against its reference model on every clock.

// File: rtl/pic_cmd_pkg.sv
// Shared types for the interrupt controller command interface.
// Assumes an 8-bit bus and eight request inputs.
package pic_cmd_pkg;
    parameter int DATA_W = 8;
    parameter int NUM_IRQ = 8;
    localparam int LVL_W = $clog2(NUM_IRQ);

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_VEC  = 3'd1,
        ST_CASC = 3'd2,
        ST_MODE = 3'd3,
        ST_RUN  = 3'd4
    } init_st_e;

    // Priority command ops (field decoded by the resolver)
    localparam logic [2:0] OP_ROT_CLR  = 3'b000;
    localparam logic [2:0] OP_EOI_NS   = 3'b001;
    localparam logic [2:0] OP_NOP      = 3'b010;
    localparam logic [2:0] OP_EOI_SP   = 3'b011;
    localparam logic [2:0] OP_ROT_SET  = 3'b100;
endpackage

// File: rtl/pic_init_seq.sv
// Initialization sequencer: walks the vector, cascade and mode steps,
// skipping the optional ones, and holds the configuration fields.
// Assumes wr_hit is a single-cycle qualified write strobe.
module pic_init_seq
    import pic_cmd_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic          a0,
    input  logic [DW-1:0] wdata,
    output logic          restart,
    output logic          init_done,
    output logic [DW-1:0] vec_base,
    output logic          level_trig,
    output logic          cascade_en,
    output logic [DW-1:0] slave_map,
    output logic          proc_mode,
    output logic          auto_eoi,
    output logic          master_sel,
    output logic          buffered,
    output logic          nest_special
);
    localparam int VLO = LVL_W;

    init_st_e st_q;
    logic need_mode_q;
    logic [DW-VLO-1:0] vec_q;
    logic [4:0] mode_q;
    logic seq_wr;

    // Restart decode and mid-sequence write qualifier
    always_comb begin
        restart = wr_hit && !a0 && wdata[4];
        seq_wr  = wr_hit && !restart;
    end

    // Sequencer state and captured words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            need_mode_q <= 1'b0;
            level_trig  <= 1'b0;
            cascade_en  <= 1'b0;
            vec_q       <= '0;
            slave_map   <= '0;
            mode_q      <= '0;
        end else if (restart) begin
            st_q        <= ST_VEC;
            need_mode_q <= wdata[0];
            cascade_en  <= !wdata[1];
            level_trig  <= wdata[3];
            vec_q       <= '0;
            slave_map   <= '0;
            mode_q      <= '0;
        end else if (seq_wr) begin
            case (st_q)
                ST_VEC: begin
                    vec_q <= wdata[DW-1:VLO];
                    if (cascade_en)       st_q <= ST_CASC;
                    else if (need_mode_q) st_q <= ST_MODE;
                    else                  st_q <= ST_RUN;
                end
                ST_CASC: begin
                    slave_map <= wdata;
                    st_q <= need_mode_q ? ST_MODE : ST_RUN;
                end
                ST_MODE: begin
                    mode_q <= wdata[4:0];
                    st_q   <= ST_RUN;
                end
                default: st_q <= st_q;
            endcase
        end
    end

    // Field outputs
    always_comb begin
        init_done    = (st_q == ST_RUN);
        vec_base     = {vec_q, {VLO{1'b0}}};
        proc_mode    = mode_q[0];
        auto_eoi     = mode_q[1];
        master_sel   = mode_q[2];
        buffered     = mode_q[3];
        nest_special = mode_q[4];
    end

    // R2
    restart_goes_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q == ST_VEC && !init_done));
    // R3
    vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_wr && st_q == ST_VEC) |=> (vec_base[DW-1:VLO] == $past(wdata[DW-1:VLO])));
    // R5
    short_seq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_wr && st_q == ST_VEC && !cascade_en && !need_mode_q) |=> init_done);
endmodule

// File: rtl/pic_op_dec.sv
// Operation command decoder: mask loads, priority commands and
// read-select commands, active only after initialization completes.
// Assumes restart comes from the sequencer and wins over all else.
module pic_op_dec
    import pic_cmd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int LW = LVL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic          rd_hit,
    input  logic          a0,
    input  logic [DW-1:0] wdata,
    input  logic          restart,
    input  logic          init_done,
    output logic [DW-1:0] mask_out,
    output logic          rd_isr,
    output logic          poll_pend,
    output logic          spec_mask,
    output logic          rot_aeoi,
    output logic          cmd_vld,
    output logic [2:0]    cmd_op,
    output logic [LW-1:0] cmd_lvl
);
    logic run_wr, mask_wr, pri_wr, sel_wr;

    // Command class decode
    always_comb begin
        run_wr  = wr_hit && init_done && !restart;
        mask_wr = run_wr && a0;
        pri_wr  = run_wr && !a0 && (wdata[4:3] == 2'b00);
        sel_wr  = run_wr && !a0 && (wdata[4:3] == 2'b01);
    end

    // Mask register
    always_ff @(posedge clk) begin
        if (!rst_n || restart) mask_out <= '0;
        else if (mask_wr)      mask_out <= wdata;
    end

    // Read select, poll arm and special mask flag
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            rd_isr    <= 1'b0;
            poll_pend <= 1'b0;
            spec_mask <= 1'b0;
        end else if (sel_wr) begin
            if (wdata[1]) rd_isr <= wdata[0];
            if (wdata[6]) spec_mask <= wdata[5];
            poll_pend <= wdata[2];
        end else if (rd_hit) begin
            poll_pend <= 1'b0;
        end
    end

    // Priority command pulse and rotate-in-auto-EOI flag
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cmd_vld  <= 1'b0;
            cmd_op   <= '0;
            cmd_lvl  <= '0;
            rot_aeoi <= 1'b0;
        end else begin
            cmd_vld <= 1'b0;
            if (pri_wr) begin
                case (wdata[7:5])
                    OP_ROT_SET: rot_aeoi <= 1'b1;
                    OP_ROT_CLR: rot_aeoi <= 1'b0;
                    OP_NOP:     ;
                    default: begin
                        cmd_vld <= 1'b1;
                        cmd_op  <= wdata[7:5];
                        cmd_lvl <= wdata[LW-1:0];
                    end
                endcase
            end
        end
    end

    // R8
    mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && a0 && !init_done) |=> $stable(mask_out));
    // R9
    cmd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |-> $past(wr_hit && !a0 && wdata[4:3] == 2'b00 && init_done));
    // R9
    cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && !$past(wr_hit)) |=> !cmd_vld);
endmodule

// File: rtl/pic_rd_mux.sv
// Read data steering among poll word, mask and the resolver vectors.
// Assumes the poll word outranks the address when a poll is armed.
module pic_rd_mux
    import pic_cmd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int LW = LVL_W
) (
    input  logic          rd_hit,
    input  logic          a0,
    input  logic          poll_pend,
    input  logic          rd_isr,
    input  logic [DW-1:0] mask_in,
    input  logic [DW-1:0] irr_in,
    input  logic [DW-1:0] isr_in,
    input  logic          poll_hit,
    input  logic [LW-1:0] poll_lvl,
    output logic [DW-1:0] rdata,
    output logic          poll_ack
);
    localparam int PAD = DW - 1 - LW;

    // Select the read source
    always_comb begin
        rdata    = '0;
        poll_ack = 1'b0;
        if (rd_hit) begin
            if (poll_pend) begin
                rdata    = {poll_hit, {PAD{1'b0}}, poll_lvl};
                poll_ack = 1'b1;
            end else if (a0) begin
                rdata = mask_in;
            end else begin
                rdata = rd_isr ? isr_in : irr_in;
            end
        end
    end
endmodule

// File: rtl/pic_cmd_if.sv
// Top of the interrupt controller command interface: qualifies the
// bus strobes and joins sequencer, decoder and read steering.
// Assumes synchronous strobes sampled on the rising edge.
module pic_cmd_if
    import pic_cmd_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs,
    input  logic         wr_stb,
    input  logic         rd_stb,
    input  logic         a0,
    input  logic [7:0]   wdata,
    output logic [7:0]   rdata,
    input  logic [7:0]   irr_in,
    input  logic [7:0]   isr_in,
    input  logic         poll_hit,
    input  logic [2:0]   poll_lvl,
    input  logic         int_req,
    output logic         int_out,
    output logic         poll_ack,
    output logic         init_done,
    output logic [7:0]   vec_base,
    output logic         level_trig,
    output logic         cascade_en,
    output logic [7:0]   slave_map,
    output logic         proc_mode,
    output logic         auto_eoi,
    output logic         master_sel,
    output logic         buffered,
    output logic         nest_special,
    output logic [7:0]   mask_out,
    output logic         spec_mask,
    output logic         rot_aeoi,
    output logic         cmd_vld,
    output logic [2:0]   cmd_op,
    output logic [2:0]   cmd_lvl
);
    logic wr_hit, rd_hit, restart, rd_isr, poll_pend;

    // Bus strobe qualification and output gating
    always_comb begin
        wr_hit  = cs && wr_stb;
        rd_hit  = cs && rd_stb;
        int_out = int_req && init_done;
    end

    pic_init_seq #(.DW(DATA_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .a0(a0), .wdata(wdata),
        .restart(restart), .init_done(init_done), .vec_base(vec_base),
        .level_trig(level_trig), .cascade_en(cascade_en), .slave_map(slave_map),
        .proc_mode(proc_mode), .auto_eoi(auto_eoi), .master_sel(master_sel),
        .buffered(buffered), .nest_special(nest_special)
    );

    pic_op_dec #(.DW(DATA_W), .LW(LVL_W)) dec_i (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .rd_hit(rd_hit), .a0(a0),
        .wdata(wdata), .restart(restart), .init_done(init_done),
        .mask_out(mask_out), .rd_isr(rd_isr), .poll_pend(poll_pend),
        .spec_mask(spec_mask), .rot_aeoi(rot_aeoi), .cmd_vld(cmd_vld),
        .cmd_op(cmd_op), .cmd_lvl(cmd_lvl)
    );

    pic_rd_mux #(.DW(DATA_W), .LW(LVL_W)) mux_i (
        .rd_hit(rd_hit), .a0(a0), .poll_pend(poll_pend), .rd_isr(rd_isr),
        .mask_in(mask_out), .irr_in(irr_in), .isr_in(isr_in),
        .poll_hit(poll_hit), .poll_lvl(poll_lvl), .rdata(rdata),
        .poll_ack(poll_ack)
    );

    // R12
    poll_ack_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_ack |=> !poll_ack);
    // R7
    int_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && int_req) |=> !int_out);
endmodule

// File: tb/pic_cmd_if_tb.sv
module pic_cmd_if_tb_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cs = 0, wr_stb = 0, rd_stb = 0, a0 = 0;
    logic [7:0] wdata = 0, irr_in = 8'h5C, isr_in = 8'h21;
    logic poll_hit = 0, int_req = 0;
    logic [2:0] poll_lvl = 0;
    logic [7:0] rdata, vec_base, slave_map, mask_out;
    logic int_out, poll_ack, init_done, level_trig, cascade_en;
    logic proc_mode, auto_eoi, master_sel, buffered, nest_special;
    logic spec_mask, rot_aeoi, cmd_vld;
    logic [2:0] cmd_op, cmd_lvl;

    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    pic_cmd_if dut_i (.*);

    // Reference model state
    int  m_st = 0;           // 0 idle,1 vec,2 cascade,3 mode,4 run
    bit  m_need4, m_casc, m_lvl, m_isr, m_poll, m_smm, m_rot, m_cv;
    byte unsigned m_vec, m_slv, m_mask;
    bit [4:0] m_mode;
    bit [2:0] m_op, m_lv;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge(input bit c, w, r, a, input byte unsigned d);
        m_cv = 0;
        if (c && w && !a && d[4]) begin
            m_st = 1; m_need4 = d[0]; m_casc = !d[1]; m_lvl = d[3];
            m_vec = 0; m_slv = 0; m_mode = 0; m_mask = 0;
            m_isr = 0; m_poll = 0; m_smm = 0; m_rot = 0; m_op = 0; m_lv = 0;
        end else if (c && w) begin
            if (m_st == 1) begin
                m_vec = d & 8'hF8;
                m_st = m_casc ? 2 : (m_need4 ? 3 : 4);
            end else if (m_st == 2) begin
                m_slv = d; m_st = m_need4 ? 3 : 4;
            end else if (m_st == 3) begin
                m_mode = d[4:0]; m_st = 4;
            end else if (m_st == 4) begin
                if (a) m_mask = d;
                else if (d[3]) begin
                    if (d[1]) m_isr = d[0];
                    if (d[6]) m_smm = d[5];
                    m_poll = d[2];
                end else begin
                    int op = d[7:5];
                    if (op == 4) m_rot = 1;
                    else if (op == 0) m_rot = 0;
                    else if (op != 2) begin m_cv = 1; m_op = d[7:5]; m_lv = d[2:0]; end
                end
            end
        end else if (c && r) m_poll = 0;
    endtask

    function automatic int exp_rdata(input bit c, r, a);
        if (!(c && r)) return 0;
        if (m_poll) return {poll_hit, 4'b0, poll_lvl};
        if (a) return m_mask;
        return m_isr ? isr_in : irr_in;
    endfunction

    task automatic check_regs(input string tag);
        chk({tag, " R3 vec_base"}, vec_base, m_vec);
        chk({tag, " R5 init_done"}, init_done, m_st == 4);
        chk({tag, " R2 level_trig"}, level_trig, m_lvl);
        chk({tag, " R4 cascade_en"}, cascade_en, m_casc);
        chk({tag, " R4 slave_map"}, slave_map, m_slv);
        chk({tag, " R5 mode"}, {nest_special, buffered, master_sel, auto_eoi, proc_mode}, m_mode);
        chk({tag, " R8 mask"}, mask_out, m_mask);
        chk({tag, " R10 spec_mask"}, spec_mask, m_smm);
        chk({tag, " R9 rot_aeoi"}, rot_aeoi, m_rot);
        chk({tag, " R9 cmd_vld"}, cmd_vld, m_cv);
        if (m_cv) chk({tag, " R9 cmd"}, {cmd_op, cmd_lvl}, {m_op, m_lv});
    endtask

    // One bus cycle: drive, check combinational outputs, clock, check registers
    task automatic step(input string tag, input bit c, w, r, a, input byte unsigned d);
        @(negedge clk);
        cs = c; wr_stb = w; rd_stb = r; a0 = a; wdata = d;
        #1;
        chk({tag, " R11 rdata"}, rdata, exp_rdata(c, r, a));
        chk({tag, " R12 poll_ack"}, poll_ack, c && r && m_poll);
        chk({tag, " R7 int_out"}, int_out, int_req && m_st == 4);
        @(posedge clk); #1;
        model_edge(c, w, r, a, d);
        check_regs(tag);
    endtask

    task automatic wr(input string tag, input bit a, input byte unsigned d);
        step(tag, 1, 1, 0, a, d);
        step({tag, " idle"}, 0, 0, 0, 0, 0);
    endtask

    task automatic rd(input string tag, input bit a);
        step(tag, 1, 0, 1, a, 0);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int_req = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        step("R1 reset", 0, 0, 0, 0, 0);
        // R8 mask write before init ignored; R7 int held off
        wr("R8 early mask", 1, 8'hFF);
        wr("R13 early cmd", 0, 8'h20);
        // R2/R3/R5 single mode, level trigger, no mode word
        wr("R2 start short", 0, 8'h1A);
        wr("R3 vector", 1, 8'h77);
        rd("R11 read irr", 0);
        rd("R11 read mask", 1);
        // R2/R4/R5/R6 cascade with mode word; cascade map via a0=0
        wr("R2 start long", 0, 8'h11);
        wr("R6 vector a0=0", 0, 8'h08);
        wr("R4 slave map", 0, 8'h04);
        wr("R5 mode word", 1, 8'h1F);
        wr("R8 mask load", 1, 8'hA5);
        rd("R11 mask readback", 1);
        // R10 read select codes
        wr("R10 sel isr", 0, 8'h0B);
        rd("R10 read isr", 0);
        wr("R10 keep", 0, 8'h08);
        rd("R10 still isr", 0);
        wr("R10 sel irr", 0, 8'h0A);
        rd("R10 read irr", 0);
        wr("R10 smm on", 0, 8'h68);
        wr("R10 smm hold", 0, 8'h28);
        wr("R10 smm off", 0, 8'h48);
        // R12 poll
        poll_hit = 1; poll_lvl = 3'd5;
        wr("R12 arm poll", 0, 8'h0C);
        rd("R12 poll read", 1);
        rd("R12 after poll", 1);
        poll_hit = 0; poll_lvl = 3'd2;
        wr("R12 arm poll2", 0, 8'h0C);
        rd("R12 poll empty", 0);
        // R9 priority commands
        wr("R9 eoi ns", 0, 8'h20);
        wr("R9 eoi sp", 0, 8'h63);
        wr("R9 rot ns", 0, 8'hA0);
        wr("R9 rot sp", 0, 8'hE5);
        wr("R9 set pri", 0, 8'hC7);
        wr("R9 nop", 0, 8'h40);
        wr("R9 rot set", 0, 8'h80);
        wr("R9 rot clr", 0, 8'h00);
        wr("R9 rot set2", 0, 8'h84);
        wr("R10 sel isr2", 0, 8'h0B);
        // R2 restart mid-run clears state; R7 output drops
        wr("R2 restart", 0, 8'h13);
        wr("R6 vec via a0=0", 0, 8'h68);
        int_req = 0;
        step("R7 req low", 0, 0, 0, 0, 0);
        wr("R5 mode again", 0, 8'h03);
        int_req = 1;
        rd("R11 final", 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule